// File: doc/BRIEF.md
# Polling Cell Receive Master

This block sits on the cell-layer side of a shared, byte-wide receive bus serving several physical-layer ports. While idle, it walks a small table of configured 5-bit port addresses, presenting one address per clock and reading the single shared cell-available line to learn whether the addressed port holds a complete cell. When an enabled table entry answers, the block holds that address and drives the active-low enable. It then collects the cell one byte per clock and returns to polling after the last byte.

Each byte pulled from the bus is forwarded on a plain output: a one-cycle valid pulse with the byte, its start-of-cell flag and the table index of the port it came from. The block keeps an offset pointer inside the cell. A start-of-cell flag always forces this pointer back to 1, so the pointer follows the bus framing rather than its own count. A start-of-cell flag that arrives in the middle of a cell is also recorded in a sticky error flag.

The port address table and the enable mask are treated as static while a cell is being transferred.

Top module: `cell_rx_poller`

## Requirements
- R1: Under reset and until the first poll hit, `phy_enb_n` is 1, `out_valid` is 0, `framing_err` is 0, and the polling index is 0, so `phy_addr` shows table entry 0.
- R2: Table entry i occupies bits [5i+4:5i] of `cfg_addr`. While no transfer is active, `phy_addr` advances by one entry per clock through entries 0 to NPORTS-1 and then wraps to 0.
- R3: A high `phy_clav` seen while a disabled entry (its `cfg_en` bit is 0) is addressed starts no transfer: `phy_enb_n` stays 1 and no byte is emitted.
- R4: When `phy_clav` is 1 in a polling cycle whose entry is enabled, `phy_enb_n` is 0 in the next cycle. `phy_addr` then holds that entry for the whole transfer.
- R5: The byte on `phy_data`/`phy_soc` is taken in the cycle after a cycle with `phy_enb_n` low. It appears on `out_data`/`out_soc` with `out_valid` high in the following cycle, which is two cycles after the enable-low cycle.
- R6: Every emitted byte carries, in `out_port`, the table index of the port being served, and in `out_soc` the sampled start-of-cell flag. The data is passed through unchanged.
- R7: For a cell with no framing fault, `phy_enb_n` is low for exactly 53 consecutive cycles and exactly 53 bytes are emitted. The first of these bytes carries `out_soc` = 1.
- R8: In the cycle where the last byte of a cell is emitted, polling has already resumed at table entry (served index + 1) mod NPORTS. As a result, ports that stay ready are served round-robin.
- R9: The offset pointer is set to 1 on any accepted byte with the start-of-cell flag set, and otherwise goes up by 1. An accepted start-of-cell byte that arrives when the pointer is neither 0 (transfer start) nor 53 sets `framing_err`, which stays 1 until reset. The transfer then continues until 52 further bytes have been taken, so the enable is low for (offset before the fault) + 53 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | NPORTS*5 | Table of port addresses, entry i at bits [5i+4:5i] |
| cfg_en | input | NPORTS | Per-entry enable; a 0 makes that entry's availability ignored |
| phy_addr | output | 5 | Address presented to the shared bus |
| phy_enb_n | output | 1 | Active-low receive enable |
| phy_clav | input | 1 | Shared cell-available line, valid for the address in the same cycle |
| phy_data | input | 8 | Received byte |
| phy_soc | input | 1 | Start-of-cell flag for the received byte |
| out_valid | output | 1 | One pulse per received byte |
| out_data | output | 8 | Received byte |
| out_soc | output | 1 | Start-of-cell flag of the emitted byte |
| out_port | output | clog2(NPORTS) | Table index of the source port |
| framing_err | output | 1 | Sticky flag for a start-of-cell byte seen in mid-cell |

## Verification
The bench builds the block with its defaults: four table entries, 53-byte cells, a 5-bit address and an 8-bit data path. Four entries are enough to show the polling wrap, a disabled entry being skipped, and alternation among several ready ports, where the bench predicts which port comes next. The full 53-byte cell length allows a mid-cell start-of-cell to be injected at any offset from 1 to 52, so the extended enable window and the sticky error can be checked at arbitrary points.

// File: rtl/cell_rx_poller.sv
module cell_rx_poller #(
  parameter int NPORTS     = 4,
  parameter int AW         = 5,
  parameter int DW         = 8,
  parameter int CELL_BYTES = 53,
  localparam int IW        = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS*AW-1:0] cfg_addr,
  input  logic [NPORTS-1:0] cfg_en,
  output logic [AW-1:0]     phy_addr,
  output logic              phy_enb_n,
  input  logic              phy_clav,
  input  logic [DW-1:0]     phy_data,
  input  logic              phy_soc,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  output logic              out_soc,
  output logic [IW-1:0]     out_port,
  output logic              framing_err
);

  localparam int OW = $clog2(CELL_BYTES + 1);
  localparam logic [OW-1:0] LAST = OW'(CELL_BYTES);

  logic          busy;
  logic          pend;
  logic [IW-1:0] poll_idx;
  logic [IW-1:0] sel;
  logic [OW-1:0] ptr;

  wire [IW-1:0] cur     = busy ? sel : poll_idx;
  wire [IW-1:0] poll_nx = (poll_idx == IW'(NPORTS - 1)) ? '0 : poll_idx + 1'b1;
  wire [IW-1:0] sel_nx  = (sel == IW'(NPORTS - 1)) ? '0 : sel + 1'b1;
  wire          hit     = !busy && phy_clav && cfg_en[poll_idx];
  wire [OW-1:0] ptr_nx  = !pend ? ptr : (phy_soc ? OW'(1) : ptr + 1'b1);
  wire [OW:0]   need    = {1'b0, ptr_nx} + {{OW{1'b0}}, ~phy_enb_n};
  wire          done    = busy && pend && (ptr_nx == LAST);
  wire          mid_soc = pend && phy_soc && (ptr != '0) && (ptr != LAST);

  assign phy_addr = cfg_addr[cur*AW +: AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      pend        <= 1'b0;
      poll_idx    <= '0;
      sel         <= '0;
      ptr         <= '0;
      phy_enb_n   <= 1'b1;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_soc     <= 1'b0;
      out_port    <= '0;
      framing_err <= 1'b0;
    end else begin
      pend      <= !phy_enb_n;
      out_valid <= pend;
      if (pend) begin
        out_data <= phy_data;
        out_soc  <= phy_soc;
        out_port <= sel;
      end
      if (mid_soc) framing_err <= 1'b1;
      if (hit) begin
        busy      <= 1'b1;
        sel       <= poll_idx;
        ptr       <= '0;
        phy_enb_n <= 1'b0;
      end else if (!busy) begin
        poll_idx <= poll_nx;
      end else begin
        ptr       <= ptr_nx;
        phy_enb_n <= !(need < (OW+1)'(CELL_BYTES));
        if (done) begin
          busy     <= 1'b0;
          poll_idx <= sel_nx;
        end
      end
    end
  end

  AST_HIT_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !phy_enb_n); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(phy_addr)); // R4
  AST_OUT_AFTER_ENB: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!phy_enb_n, 2)); // R5
  AST_ENB_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_enb_n |-> busy); // R7
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(framing_err) |-> framing_err); // R9

endmodule

// File: tb/cell_rx_poller_tb_top.sv
`timescale 1ns/1ps
module cell_rx_poller_tb_top;
  localparam int NP = 4;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int CB = 53;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP*AW-1:0] cfg_addr = {5'd21, 5'd3, 5'd17, 5'd9};
  logic [NP-1:0]    cfg_en = '1;
  logic [AW-1:0]    phy_addr;
  logic             phy_enb_n;
  logic             phy_clav;
  logic [DW-1:0]    phy_data = '0;
  logic             phy_soc = 1'b0;
  logic             out_valid;
  logic [DW-1:0]    out_data;
  logic             out_soc;
  logic [1:0]       out_port;
  logic             framing_err;

  cell_rx_poller #(.NPORTS(NP), .AW(AW), .DW(DW), .CELL_BYTES(CB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_en(cfg_en),
    .phy_addr(phy_addr), .phy_enb_n(phy_enb_n), .phy_clav(phy_clav),
    .phy_data(phy_data), .phy_soc(phy_soc), .out_valid(out_valid),
    .out_data(out_data), .out_soc(out_soc), .out_port(out_port),
    .framing_err(framing_err));

  int checks = 0;
  int errors = 0;
  int cells_left[NP];
  int off[NP];
  int load_cells[NP];
  int load_inj = 0;
  int load_seq = 0;
  int seen_seq = 0;
  int armed = 0;
  int rr = 0;
  int mon_off = 0;
  int cur_port = 0;
  int enb_cnt = 0;
  int extra = 0;
  int cells_done = 0;
  int h1 = 0;
  int h2 = 0;
  bit err_exp = 1'b0;
  bit prev_hit = 1'b0;

  always_comb begin
    phy_clav = 1'b0;
    for (int i = 0; i < NP; i++)
      if (cfg_addr[i*AW +: AW] == phy_addr && cells_left[i] > 0) phy_clav = 1'b1;
  end

  function automatic int idx_of(logic [AW-1:0] a);
    for (int i = 0; i < NP; i++) if (cfg_addr[i*AW +: AW] == a) return i;
    return -1;
  endfunction

  function automatic logic [7:0] byte_of(int p, int o);
    return 8'((p * 67 + o * 13 + 5) & 255);
  endfunction

  function automatic int pick(int r);
    for (int k = 0; k < NP; k++) begin
      int i;
      i = (r + k) % NP;
      if (cfg_en[i] && cells_left[i] > 0) return i;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_loop();
    forever begin
      @(negedge clk);
      if (load_seq != seen_seq) begin
        seen_seq = load_seq;
        for (int i = 0; i < NP; i++) cells_left[i] = load_cells[i];
        armed = load_inj;
        rr = idx_of(phy_addr);
      end
      if (rst_n) begin
        if (prev_hit) chk(!phy_enb_n, "R4", int'(phy_enb_n), 0);
        if (out_valid) begin
          chk(h2 == 1, "R5", h2, 1);
          if (out_soc) begin
            if (mon_off != 0) begin
              extra = mon_off;
              err_exp = 1'b1;
              chk(framing_err == 1'b1, "R9", int'(framing_err), 1);
            end else begin
              cur_port = pick(rr);
              chk(int'(out_port) == cur_port, "R6", int'(out_port), cur_port);
            end
            chk(out_data == byte_of(cur_port, 0), "R6", int'(out_data), int'(byte_of(cur_port, 0)));
            mon_off = 1;
          end else begin
            chk(mon_off != 0, "R7", int'(out_soc), 1);
            chk(out_data == byte_of(cur_port, mon_off) && int'(out_port) == cur_port, "R6",
                int'(out_data), int'(byte_of(cur_port, mon_off)));
            mon_off++;
          end
          if (mon_off == CB) begin
            chk(enb_cnt == CB + extra, "R7", enb_cnt, CB + extra);
            chk(idx_of(phy_addr) == (cur_port + 1) % NP, "R8", idx_of(phy_addr), (cur_port + 1) % NP);
            chk(framing_err == err_exp, "R9", int'(framing_err), int'(err_exp));
            rr = (cur_port + 1) % NP;
            enb_cnt = 0;
            extra = 0;
            mon_off = 0;
            cells_done++;
          end
        end
        begin
          int ix;
          ix = idx_of(phy_addr);
          prev_hit = phy_clav && ix >= 0 && cfg_en[ix] && phy_enb_n && mon_off == 0;
        end
        if (!phy_enb_n) enb_cnt++;
        h2 = h1;
        h1 = phy_enb_n ? 0 : 1;
      end
      @(posedge clk);
      if (rst_n && !phy_enb_n) begin
        int i;
        i = idx_of(phy_addr);
        if (armed > 0 && off[i] == armed) begin
          phy_soc  <= 1'b1;
          phy_data <= byte_of(i, 0);
          off[i] = 1;
          armed = 0;
        end else begin
          phy_soc  <= (off[i] == 0);
          phy_data <= byte_of(i, off[i]);
          if (off[i] == CB - 1) begin
            off[i] = 0;
            cells_left[i] = cells_left[i] - 1;
          end else begin
            off[i] = off[i] + 1;
          end
        end
      end else begin
        phy_soc <= 1'b0;
      end
    end
  endtask

  task automatic load(int c0, int c1, int c2, int c3, int inj);
    @(posedge clk); #1;
    load_cells[0] = c0; load_cells[1] = c1; load_cells[2] = c2; load_cells[3] = c3;
    load_inj = inj;
    load_seq++;
    @(negedge clk); #1;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    forever begin
      bit idle;
      @(negedge clk); #1;
      idle = (mon_off == 0) && phy_enb_n;
      for (int i = 0; i < NP; i++) if (cfg_en[i] && cells_left[i] > 0) idle = 1'b0;
      if (idle) break;
      guard++;
      if (guard > 6000) begin
        chk(1'b0, "R7", guard, 0);
        break;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic stimulus();
    int base;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NP; i++) begin
      cells_left[i] = 0; off[i] = 0; load_cells[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(phy_enb_n == 1'b1, "R1", int'(phy_enb_n), 1);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(framing_err == 1'b0, "R1", int'(framing_err), 0);
    chk(idx_of(phy_addr) == 0, "R1", idx_of(phy_addr), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    base = idx_of(phy_addr);
    chk(base == 0, "R1", base, 0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk(idx_of(phy_addr) == (base + k) % NP, "R2", idx_of(phy_addr), (base + k) % NP);
    end
    // R3: disabled entry with a waiting cell
    @(posedge clk); #1 cfg_en = 4'b1101;
    base = cells_done;
    load(0, 1, 0, 0, 0);
    repeat (20) @(negedge clk);
    chk(enb_cnt == 0 && phy_enb_n, "R3", enb_cnt, 0);
    chk(cells_done == base, "R3", cells_done, base);
    @(posedge clk); #1 cfg_en = 4'b1111;
    drain();
    chk(cells_done == base + 1, "R3", cells_done, base + 1);
    // R8: two ports with two cells each alternate
    base = cells_done;
    load(2, 0, 2, 0, 0);
    drain();
    chk(cells_done == base + 4, "R8", cells_done, base + 4);
    // R9: mid-cell start-of-cell at offset 20
    chk(framing_err == 1'b0, "R9", int'(framing_err), 0);
    load(1, 0, 0, 0, 20);
    drain();
    chk(framing_err == 1'b1, "R9", int'(framing_err), 1);
    load(0, 0, 0, 0, 0);
    // random rounds
    for (int r = 0; r < 24; r++) begin
      @(posedge clk); #1 cfg_en = 4'($urandom);
      load(int'($urandom % 3), int'($urandom % 3), int'($urandom % 3), int'($urandom % 3),
           (r % 5 == 2) ? int'(1 + $urandom % 52) : 0);
      drain();
      load(0, 0, 0, 0, 0);
    end
    chk(framing_err == 1'b1, "R9", int'(framing_err), 1);
  endtask

  task automatic watchdog();
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", 0, 1);
  endtask

  initial begin
    fork
      model_loop();
      stimulus();
      watchdog();
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule